// File: doc/BRIEF.md
# Load Data Unpack and Align Unit

This block sits between the data-memory read port and the register-file write port of a processor pipeline. It takes the raw read data of a load, already shifted down so that the accessed bytes start at bit 0, and turns it into the value that is written to the destination register or register pair. The operation code picks the kind of load. The sign flag picks sign or zero extension where that choice applies. For the align loads, the old 64-bit destination value is taken in as well.

Three families of loads are covered. Plain loads extend a byte or a half to 32 bits, pass a word through, or pass a 64-bit double through to a register pair. Unpack loads widen each loaded byte into its own 16-bit lane: two bytes go into a 32-bit register, or four bytes go into a 64-bit pair. Align loads shift the old 64-bit pair right by the access size and insert the new byte or half at the top. This builds a sliding window over a byte stream. The result appears on a registered output one clock after a valid request.

Top module: `ld_fmt_unit`

## Requirements
- R1: While reset is high, and at the first clock edge after it is asserted, out_valid becomes 0 and out_data becomes all zeros.
- R2: out_valid equals the in_valid of the previous clock edge. out_data changes only one clock after a cycle with in_valid high, and otherwise holds its value.
- R3: op 0 (byte): bits [31:0] are rd_data[7:0], extended with its bit 7 when sign_ext is 1 and with zeros when sign_ext is 0. Bits [63:32] are zero.
- R4: op 1 (half): bits [31:0] are rd_data[15:0], extended with its bit 15 when sign_ext is 1 and with zeros when sign_ext is 0. Bits [63:32] are zero.
- R5: op 2 (word): bits [31:0] are rd_data[31:0] and bits [63:32] are zero, whatever the value of sign_ext.
- R6: op 3 (double): out_data is rd_data[63:0], whatever the value of sign_ext.
- R7: op 4 (two-byte unpack): for i = 0 and 1, halfword i (bits [16i+15:16i]) is byte i of rd_data, extended to 16 bits by its bit 7 when sign_ext is 1 and with zeros when sign_ext is 0. Bits [63:32] are zero.
- R8: op 5 (four-byte unpack): for i = 0 to 3, halfword i of out_data is byte i of rd_data, extended as in R7.
- R9: op 6 (byte align): out_data is old_dst shifted right by 8, with rd_data[7:0] placed in bits [63:56]. sign_ext has no effect.
- R10: op 7 (half align): out_data is old_dst shifted right by 16, with rd_data[15:0] placed in bits [63:48]. sign_ext has no effect.
- R11: rd_data bits above the access size of the operation (8, 16, 32 or 64 bits) have no effect on out_data. For ops 4 to 7, old_dst has an effect only in ops 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid this cycle |
| op | input | 3 | Load kind, encoded as in R3 to R10 |
| sign_ext | input | 1 | 1 = sign-extend, 0 = zero-extend |
| rd_data | input | 64 | Raw read data, aligned to bit 0 |
| old_dst | input | 64 | Current value of the destination pair (align loads) |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Formatted destination value |

## Verification
The hardest case to reach is R11: it asks that data the operation should not look at has no effect. To test it, the stimulus fills the unused upper rd_data bits with a pattern, and fills old_dst for every non-align operation, with values whose leakage would change the result. Align loads are sent back to back, with each old_dst taken from the previous result, so the shift chain is checked over several steps. Idle cycles are put between valid cycles to show that the output holds.

// File: rtl/ld_fmt_pkg.sv
package ld_fmt_pkg;
  typedef enum logic [2:0] {
    OP_LDB   = 3'd0,
    OP_LDH   = 3'd1,
    OP_LDW   = 3'd2,
    OP_LDD   = 3'd3,
    OP_UNPK2 = 3'd4,
    OP_UNPK4 = 3'd5,
    OP_ALNB  = 3'd6,
    OP_ALNH  = 3'd7
  } ld_op_e;
endpackage

// File: rtl/ld_fmt_extend.sv
module ld_fmt_extend
  import ld_fmt_pkg::*;
#(
  parameter int DW = 64
) (
  input  ld_op_e          op,
  input  logic            sign_ext,
  input  logic [DW-1:0]   rd_data,
  output logic [DW-1:0]   res
);
  localparam int HW = DW / 2;
  localparam int BW = 8;
  localparam int SW = 16;

  logic b_msb, h_msb;
  assign b_msb = sign_ext & rd_data[BW-1];
  assign h_msb = sign_ext & rd_data[SW-1];

  always_comb begin
    case (op)
      OP_LDB:  res = {{HW{1'b0}}, {(HW-BW){b_msb}}, rd_data[BW-1:0]};
      OP_LDH:  res = {{HW{1'b0}}, {(HW-SW){h_msb}}, rd_data[SW-1:0]};
      OP_LDW:  res = {{HW{1'b0}}, rd_data[HW-1:0]};
      default: res = rd_data;
    endcase
  end
endmodule

// File: rtl/ld_fmt_unpack.sv
module ld_fmt_unpack #(
  parameter int DW = 64
) (
  input  logic              wide,
  input  logic              sign_ext,
  input  logic [DW/2-1:0]   rd_lo,
  output logic [DW-1:0]     res
);
  localparam int BW    = 8;
  localparam int LW    = 2 * BW;
  localparam int LANES = DW / LW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BW-1:0] byte_in;
    logic          lane_on;
    assign byte_in = rd_lo[g*BW +: BW];
    assign lane_on = (g < LANES / 2) ? 1'b1 : wide;
    assign res[g*LW +: LW] = lane_on ? {{BW{sign_ext & byte_in[BW-1]}}, byte_in}
                                     : '0;
  end
endmodule

// File: rtl/ld_fmt_align.sv
module ld_fmt_align #(
  parameter int DW = 64
) (
  input  logic            half,
  input  logic [15:0]     ins,
  input  logic [DW-1:0]   old_dst,
  output logic [DW-1:0]   res
);
  always_comb begin
    if (half) res = {ins, old_dst[DW-1:16]};
    else      res = {ins[7:0], old_dst[DW-1:8]};
  end
endmodule

// File: rtl/ld_fmt_unit.sv
module ld_fmt_unit
  import ld_fmt_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      op,
  input  logic            sign_ext,
  input  logic [DW-1:0]   rd_data,
  input  logic [DW-1:0]   old_dst,
  output logic            out_valid,
  output logic [DW-1:0]   out_data
);
  ld_op_e        op_e;
  logic [DW-1:0] ext_res, unp_res, aln_res, nxt;

  assign op_e = ld_op_e'(op);

  ld_fmt_extend #(.DW(DW)) u_ext (
    .op(op_e), .sign_ext(sign_ext), .rd_data(rd_data), .res(ext_res)
  );

  ld_fmt_unpack #(.DW(DW)) u_unp (
    .wide(op_e == OP_UNPK4), .sign_ext(sign_ext),
    .rd_lo(rd_data[DW/2-1:0]), .res(unp_res)
  );

  ld_fmt_align #(.DW(DW)) u_aln (
    .half(op_e == OP_ALNH), .ins(rd_data[15:0]),
    .old_dst(old_dst), .res(aln_res)
  );

  always_comb begin
    case (op_e)
      OP_UNPK2, OP_UNPK4: nxt = unp_res;
      OP_ALNB, OP_ALNH:   nxt = aln_res;
      default:            nxt = ext_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end
endmodule

// File: rtl/ld_fmt_unit_chk.sv
module ld_fmt_unit_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    op,
  input logic          sign_ext,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] old_dst,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data)); // R2
  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd2) |=> out_data == {32'h0, $past(rd_data[31:0])}); // R5
  AST_DOUBLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd3) |=> out_data == $past(rd_data)); // R6
  AST_UNPK_ZERO_HI: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd5 && !sign_ext) |=>
      (out_data[15:8] == 8'h0 && out_data[31:24] == 8'h0 &&
       out_data[47:40] == 8'h0 && out_data[63:56] == 8'h0)); // R8
  AST_ALNB_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd6) |=> out_data[DW-9:0] == $past(old_dst[DW-1:8])); // R9
  AST_ALNH_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd7) |=> out_data[DW-17:0] == $past(old_dst[DW-1:16])); // R10
endmodule

bind ld_fmt_unit ld_fmt_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .sign_ext(sign_ext),
  .rd_data(rd_data), .old_dst(old_dst), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/ld_fmt_unit_bench.sv
module ld_fmt_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        sign_ext = 1'b0;
  logic [63:0] rd_data = '0;
  logic [63:0] old_dst = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int vectors = 0;
  int fails = 0;
  logic        exp_valid = 1'b0;
  logic [63:0] exp_data = '0;
  string       exp_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_fmt_unit u_ld_fmt_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .sign_ext(sign_ext),
    .rd_data(rd_data), .old_dst(old_dst), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] ref_fmt(int k, bit sg, logic [63:0] rd, logic [63:0] old);
    logic [63:0] r;
    logic [7:0]  b;
    r = '0;
    case (k)
      0: begin r = {56'h0, rd[7:0]};  if (sg && rd[7])  r[31:8]  = 24'hFFFFFF; end
      1: begin r = {48'h0, rd[15:0]}; if (sg && rd[15]) r[31:16] = 16'hFFFF; end
      2: r = {32'h0, rd[31:0]};
      3: r = rd;
      4, 5: for (int i = 0; i < ((k == 4) ? 2 : 4); i++) begin
        b = rd[8*i +: 8];
        r[16*i +: 16] = {(sg && b[7]) ? 8'hFF : 8'h00, b};
      end
      6: r = (old >> 8)  | ({56'h0, rd[7:0]}  << 56);
      default: r = (old >> 16) | ({48'h0, rd[15:0]} << 48);
    endcase
    return r;
  endfunction

  function automatic string tag_of(int k);
    case (k)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_now();
    vectors++;
    if (out_valid !== exp_valid || out_data !== exp_data) begin
      fails++;
      $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
               exp_tag, out_valid, out_data, exp_valid, exp_data);
    end
  endtask

  // Check the outputs caused by the previous cycle, then drive the next cycle.
  task automatic step(bit r, bit v, int k, bit sg, logic [63:0] rd, logic [63:0] old, string xtag);
    @(negedge clk);
    check_now();
    rst = r; in_valid = v; op = 3'(k); sign_ext = sg; rd_data = rd; old_dst = old;
    if (r) begin
      exp_valid = 1'b0; exp_data = '0; exp_tag = "R1";
    end else if (v) begin
      exp_valid = 1'b1; exp_data = ref_fmt(k, sg, rd, old);
      exp_tag = (xtag != "") ? xtag : tag_of(k);
    end else begin
      exp_valid = 1'b0; exp_tag = "R2";
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R2: watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [63:0] acc;
    repeat (3) step(1, 0, 0, 0, '0, '0, "");
    // R3 / R4 sign and zero extension, with junk above the access size (R11)
    step(0, 1, 0, 1, 64'hDEADBEEF_12345680, 64'hFFFF_FFFF_FFFF_FFFF, "");
    step(0, 1, 0, 0, 64'hDEADBEEF_12345680, 64'hFFFF_FFFF_FFFF_FFFF, "R11");
    step(0, 1, 0, 1, 64'hFFFFFFFF_FFFFFF7F, '0, "R11");
    step(0, 1, 1, 1, 64'h0000_0000_0000_8001, '0, "");
    step(0, 1, 1, 0, 64'hABCD_0000_5555_8001, '0, "R11");
    step(0, 0, 0, 0, '0, '0, "");            // idle: hold (R2)
    step(0, 0, 3, 1, 64'h1111, 64'h2222, ""); // idle with junk inputs: hold (R2)
    // R5 / R6 sign ignored
    step(0, 1, 2, 1, 64'hFFFF_0000_8000_0001, '0, "");
    step(0, 1, 3, 1, 64'h8123_4567_89AB_CDEF, 64'h5A5A, "");
    // R7 / R8 unpack
    step(0, 1, 4, 1, 64'hFFFF_FFFF_FFFF_7F80, '0, "");
    step(0, 1, 4, 0, 64'h1234_5678_9ABC_7F80, '0, "R11");
    step(0, 1, 5, 1, 64'h0000_0000_807F_01FF, '0, "");
    step(0, 1, 5, 0, 64'hFFFF_FFFF_807F_01FF, 64'h1, "R11");
    // R9 / R10 align chains, old_dst fed from the previous result
    acc = 64'h0123_4567_89AB_CDEF;
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 6, i[0], 64'hFFFF_FF00 | 64'(8'hA0 + i), acc, "");
      acc = ref_fmt(6, i[0], 64'hFFFF_FF00 | 64'(8'hA0 + i), acc);
    end
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 7, 1, 64'hEEEE_0000 | 64'(16'h8000 + i), acc, "");
      acc = ref_fmt(7, 1, 64'hEEEE_0000 | 64'(16'h8000 + i), acc);
    end
    // R1 reset mid-run with valid asserted
    step(1, 1, 3, 0, 64'hFFFF, '0, "");
    step(0, 0, 0, 0, '0, '0, "");
    // random mix
    for (int n = 0; n < 400; n++) begin
      step(0, ($urandom % 4) != 0, int'($urandom % 8), 1'($urandom),
           {$urandom, $urandom}, {$urandom, $urandom}, "");
    end
    step(0, 0, 0, 0, '0, '0, "");
    @(negedge clk);
    check_now();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule